// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Host Engine

This block runs complete transactions on a three-wire serial link to a timekeeping chip. The link has a chip-enable line, a serial clock and one shared data line; the host drives the data line through a separate output-enable. A parallel request gives a command byte and a count of data bytes. The block then works through the whole sequence. It holds all lines low, raises enable, shifts out the command and moves the data bytes, then drops every line.

The direction of the data phase comes from bit 0 of the command byte. Write bytes come in through a byte-wide valid/ready port and read bytes leave through another. Either side may stall, and while it does the serial clock waits high. Every setup, phase and sampling time is a parameter counted in system-clock cycles, so the minimum bus times hold at any system clock frequency. A count of one gives a single-register access. A larger count gives a burst, for example the seven clock registers read after command 0xBF, or seven clock bytes plus a closing 0x80 after command 0xBE. A count of zero sends the command alone.

Top module: `tw_rtc_host`

## Requirements
- R1: The command byte from the request goes out unchanged. It is laid out as bit 7 = 1, bit 6 = 1 for RAM and 0 for clock registers, bits 5..1 = address, and bit 0 = 1 for read and 0 for write. Bit 0 alone selects the direction of the data phase.
- R2: Every byte crosses the data line least significant bit first, in both directions.
- R3: A host bit is driven (bus_doe = 1) while the clock is low and is unchanged at the rising edge. A read bit is captured exactly SAMPLE_CYC cycles after the falling edge, and with bus_doe = 0.
- R4: A transaction starts with enable, clock and data all low for at least CE_SETUP_CYC cycles. Enable then rises with the clock low, and at least CE_SETUP_CYC cycles pass before the first rising clock edge.
- R5: Every clock-low phase and every clock-high phase lasts at least HALF_CYC cycles.
- R6: After the command byte and after every data byte, enable and clock stay high. In a read phase, each falling edge is the point at which the chip presents the next bit.
- R7: A transaction ends with enable, clock, data and output-enable all low, and they stay low while the block is idle.
- R8: A request with count N moves exactly N data bytes after the command, all inside one enable window (N = 0 to 2^LEN_W-1).
- R9: Output-enable is high only during command bits and write-data bits, only with enable high, and it is low for at least one cycle before the first falling edge of a read phase.
- R10: busy rises on the cycle after a request is accepted and stays high until the idle state; req_ready is low and requests are refused while busy.
- R11: wr_ready is offered only when the next write byte is due, and the clock holds high until it is taken. rd_valid, together with a stable rd_data, holds until rd_ready; the clock holds high meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_cmd | input | 8 | Command byte |
| req_len | input | LEN_W | Number of data bytes after the command |
| busy | output | 1 | Transaction in progress |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle when high |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken this cycle when high |
| rd_data | output | 8 | Read byte |
| bus_ce | output | 1 | Serial chip enable, active high |
| bus_sclk | output | 1 | Serial clock |
| bus_dout | output | 1 | Data value driven by the host |
| bus_doe | output | 1 | Host drive enable for the data line |
| bus_din | input | 1 | Data line as seen by the host |

## Verification
The embedded properties assume that SAMPLE_CYC lies between 1 and HALF_CYC-1. They also assume that the attached chip changes the data line only after a falling clock edge in a read phase and releases it when enable drops. The bench keeps to this with a chip model that drives bus_din only in the read phase. That model updates the line one half system cycle after it sees the clock fall, and it checks at every cycle that the host is not driving at the same time. Requests are issued only while req_ready is high, except for a deliberate refusal probe. Write bytes are offered through the handshake, with stalls long enough to hold the bus between bytes.

// File: rtl/tw_rtc_pkg.sv
package tw_rtc_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PRE   = 3'd1,
    S_CESET = 3'd2,
    S_LOW   = 3'd3,
    S_HIGH  = 3'd4,
    S_GAP   = 3'd5,
    S_PUSH  = 3'd6,
    S_END   = 3'd7
  } tw_state_e;

  // width of a phase counter able to reach the larger of two cycle limits
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // one step of a least-significant-bit-first shift: new bit enters at the top
  function automatic logic [BYTE_W-1:0] lsb_first_step(input logic [BYTE_W-1:0] cur,
                                                       input logic b);
    return {b, cur[BYTE_W-1:1]};
  endfunction

endpackage

// File: rtl/tw_tick_timer.sv
module tw_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  // counts cycles since the last restart, saturating at all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (restart)   cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter
  import tw_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  input  logic              shift_in,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= lsb_first_step(q, shift_in);
  end
endmodule

// File: rtl/tw_line_regs.sv
module tw_line_regs #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // glitch-free registered pad lines, all low out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/tw_rtc_host.sv
module tw_rtc_host
  import tw_rtc_pkg::*;
#(
  parameter int unsigned CE_SETUP_CYC = 200,
  parameter int unsigned HALF_CYC     = 50,
  parameter int unsigned SAMPLE_CYC   = 40,  // 1 .. HALF_CYC-1
  parameter int unsigned LEN_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              bus_ce,
  output logic              bus_sclk,
  output logic              bus_dout,
  output logic              bus_doe,
  input  logic              bus_din
);
  localparam int unsigned TW       = cnt_bits(CE_SETUP_CYC, HALF_CYC);
  localparam int unsigned BIT_W    = $clog2(BYTE_W);
  localparam logic [TW-1:0] CE_LAST   = TW'(CE_SETUP_CYC - 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
  // the pad registers lag the state by one cycle, so the capture point is
  // SAMPLE_CYC counts into the low state, i.e. SAMPLE_CYC cycles after the pin falls
  localparam logic [TW-1:0] SMP_AT    = TW'(SAMPLE_CYC);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  tw_state_e state_q, state_d;
  logic [TW-1:0]    cnt;
  logic             restart;
  logic             rd_q, is_cmd_q;
  logic [LEN_W-1:0] left_q;
  logic [BIT_W-1:0] bit_q;
  logic [BYTE_W-1:0] sh_q;

  // named internal events
  logic wr_bit, ce_done, half_done;
  logic acc_evt, bit_end_evt, byte_end_evt, smp_evt, shout_evt;
  logic gap_go, wr_acc_evt, more_bytes;
  logic [3:0] lines_d, lines_q;

  assign wr_bit       = is_cmd_q | ~rd_q;
  assign ce_done      = (cnt == CE_LAST);
  assign half_done    = (cnt == HALF_LAST);
  assign acc_evt      = (state_q == S_IDLE) && req_valid;
  assign bit_end_evt  = (state_q == S_HIGH) && half_done;
  assign byte_end_evt = bit_end_evt && (bit_q == LAST_BIT);
  assign smp_evt      = (state_q == S_LOW) && !wr_bit && (cnt == SMP_AT);
  assign shout_evt    = bit_end_evt && wr_bit;
  assign more_bytes   = (left_q != '0);
  assign gap_go       = (state_q == S_GAP) && more_bytes && (rd_q || wr_valid);
  assign wr_acc_evt   = (state_q == S_GAP) && more_bytes && !rd_q && wr_valid;

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign wr_ready  = (state_q == S_GAP) && more_bytes && !rd_q;
  assign rd_valid  = (state_q == S_PUSH);
  assign rd_data   = sh_q;

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid) state_d = S_PRE;
      S_PRE:   if (ce_done)   state_d = S_CESET;
      S_CESET: if (ce_done)   state_d = S_LOW;
      S_LOW:   if (half_done) state_d = S_HIGH;
      S_HIGH: begin
        if (byte_end_evt)     state_d = wr_bit ? S_GAP : S_PUSH;
        else if (bit_end_evt) state_d = S_LOW;
      end
      S_PUSH:  if (rd_ready)  state_d = S_GAP;
      S_GAP: begin
        if (!more_bytes)      state_d = S_END;
        else if (gap_go)      state_d = S_LOW;
      end
      S_END:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // ---------------- transaction bookkeeping ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      is_cmd_q <= 1'b0;
      left_q   <= '0;
      bit_q    <= '0;
    end else begin
      if (acc_evt) begin
        rd_q     <= req_cmd[0];
        is_cmd_q <= 1'b1;
        left_q   <= req_len;
        bit_q    <= '0;
      end
      if (bit_end_evt) begin
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) is_cmd_q <= 1'b0;
      end
      if (gap_go) left_q <= left_q - 1'b1;
    end
  end

  tw_tick_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt)
  );

  tw_byte_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_evt | wr_acc_evt),
    .load_val (acc_evt ? req_cmd : wr_data),
    .shift    (shout_evt | smp_evt),
    .shift_in (smp_evt & bus_din),
    .q        (sh_q)
  );

  // ---------------- pad line decode: {ce, sclk, doe, dout} ----------------
  always_comb begin
    lines_d = 4'b0000;
    unique case (state_q)
      S_CESET:        lines_d = 4'b1000;
      S_LOW:          lines_d = {1'b1, 1'b0, wr_bit, wr_bit & sh_q[0]};
      S_HIGH:         lines_d = {1'b1, 1'b1, wr_bit, wr_bit & sh_q[0]};
      S_GAP, S_PUSH:  lines_d = 4'b1100;
      default:        lines_d = 4'b0000;
    endcase
  end

  tw_line_regs #(.W(4)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lines_d),
    .q     (lines_q)
  );

  assign bus_ce   = lines_q[3];
  assign bus_sclk = lines_q[2];
  assign bus_doe  = lines_q[1];
  assign bus_dout = lines_q[0];

  // ---------------- assertions ----------------
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy); // R10

  AST_DOE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_ce); // R9

  AST_CAPTURE_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_evt |-> bus_ce && !bus_sclk && !bus_doe); // R3

  AST_WRITE_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sclk) && bus_doe |-> $stable(bus_dout)); // R3

  AST_CE_RISE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ce) |-> !bus_sclk && !bus_doe && !bus_dout); // R4

  AST_CE_FALL_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ce) |-> !bus_sclk && !bus_doe && !bus_dout); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_ce && !bus_sclk && !bus_doe && !bus_dout); // R7

  AST_BYTE_GAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready || rd_valid) |-> bus_ce && bus_sclk); // R6

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R11

  AST_WRITE_STALL_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && !wr_valid |=> $stable(bus_sclk)); // R11

endmodule

// File: tb/tw_rtc_host_tb.sv
`timescale 1ns/1ps
module tw_rtc_host_tb;
  localparam int CE   = 6;
  localparam int HALF = 4;
  localparam int SMP  = 3;
  localparam int LW   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [7:0] req_cmd;
  logic [LW-1:0] req_len;
  logic busy;
  logic wr_valid;
  logic wr_ready;
  logic [7:0] wr_data;
  logic rd_valid;
  logic rd_ready;
  logic [7:0] rd_data;
  logic bus_ce, bus_sclk, bus_dout, bus_doe;
  logic bus_din;

  always #2.5 clk = ~clk;

  tw_rtc_host #(.CE_SETUP_CYC(CE), .HALF_CYC(HALF), .SAMPLE_CYC(SMP), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_len(req_len),
    .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_ce(bus_ce), .bus_sclk(bus_sclk), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_bus_q[$];
  logic [7:0] rd_exp_q[$];
  logic [7:0] wr_src_q[$];
  int cur_n = 0;
  int wr_stall = 0;
  int rd_period = 1;

  function automatic logic [7:0] rsp(input logic [7:0] c, input int k);
    return (c ^ 8'h5A) + 8'(k * 37);
  endfunction

  function automatic logic [7:0] wdat(input logic [7:0] c, input int k);
    if (c == 8'h8E) return 8'h00;
    if (c == 8'hBE && k == 7) return 8'h80;
    return 8'(c + k * 19 + 3);
  endfunction

  // ---------------- chip model / bus monitor ----------------
  logic ce_p, sclk_p, doe_p, dout_p;
  int quiet, ce_age, low_cnt, high_cnt;
  int byte_idx, bitc, rbyte, rbit;
  bit first_rise, dev_rd, dev_drv;
  logic [7:0] sh, dev_cmd;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_din = 1'b0;
      ce_p = 0; sclk_p = 0; doe_p = 0; dout_p = 0;
      quiet = 0; ce_age = 0; low_cnt = 0; high_cnt = 0;
      byte_idx = 0; bitc = 0; rbyte = 0; rbit = 0;
      first_rise = 0; dev_rd = 0; dev_drv = 0; sh = 0; dev_cmd = 0;
    end else begin
      if (ce_p && !bus_ce) begin
        chk(!bus_sclk && !bus_dout && !bus_doe, "R7 lines low at end", {bus_sclk, bus_dout, bus_doe}, 0);
        if (dev_rd) chk(rbyte == cur_n, "R8 read bytes in window", rbyte, cur_n);
        else        chk(byte_idx == cur_n + 1, "R8 bytes in window", byte_idx, cur_n + 1);
        dev_drv = 0;
        bus_din = 1'b0;
      end
      if (!bus_ce) begin
        if (!bus_sclk && !bus_dout && !bus_doe) quiet++;
        else quiet = 0;
      end
      if (!ce_p && bus_ce) begin
        chk(quiet >= CE, "R4 lines low before enable", quiet, CE);
        chk(!bus_sclk, "R4 clock low at enable rise", bus_sclk, 0);
        ce_age = 0; first_rise = 1; byte_idx = 0; bitc = 0;
        rbyte = 0; rbit = 0; dev_rd = 0; low_cnt = 0; high_cnt = 0;
      end
      if (bus_ce) ce_age++;
      if (bus_ce && ce_p && bus_sclk && !sclk_p) begin
        if (first_rise) begin
          chk(ce_age > CE, "R4 enable setup before first edge", ce_age, CE);
          first_rise = 0;
        end
        chk(low_cnt >= HALF, "R5 low phase", low_cnt, HALF);
        if (byte_idx == 0 || !dev_rd) begin
          logic [7:0] nsh;
          chk(bus_doe && (bus_dout == dout_p), "R3 write bit held at rise",
              {bus_doe, bus_dout}, {1'b1, dout_p});
          nsh = {bus_dout, sh[7:1]};
          sh = nsh;
          bitc++;
          if (bitc == 8) begin
            logic [7:0] e;
            e = (exp_bus_q.size() > 0) ? exp_bus_q.pop_front() : 8'hxx;
            chk(nsh === e, "R1 R2 bus byte", nsh, e);
            if (byte_idx == 0) begin dev_cmd = nsh; dev_rd = nsh[0]; end
            byte_idx++;
            bitc = 0;
          end
        end
        high_cnt = 0;
      end
      if (bus_ce && ce_p && !bus_sclk && sclk_p) begin
        chk(high_cnt >= HALF, "R5 high phase", high_cnt, HALF);
        low_cnt = 0;
        if (dev_rd && byte_idx >= 1) begin
          logic [7:0] rb;
          chk(!bus_doe && !doe_p, "R9 drive released before read edge", {doe_p, bus_doe}, 0);
          rb = rsp(dev_cmd, rbyte);
          bus_din = rb[rbit];
          dev_drv = 1;
          rbit++;
          if (rbit == 8) begin rbit = 0; rbyte++; end
        end
      end
      if (bus_ce) begin
        if (bus_sclk) high_cnt++;
        else          low_cnt++;
      end
      if (dev_drv) chk(!bus_doe, "R9 no drive contention", bus_doe, 0);
      ce_p = bus_ce; sclk_p = bus_sclk; doe_p = bus_doe; dout_p = bus_dout;
    end
  end

  // ---------------- write byte source ----------------
  bit wr_hs;
  int wr_wait;
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_valid = 0; wr_data = 0; wr_hs = 0; wr_wait = 0;
    end else begin
      if (wr_hs) begin
        void'(wr_src_q.pop_front());
        wr_valid = 0;
        wr_wait = 0;
      end
      if (wr_ready && !wr_valid)
        chk(bus_sclk && bus_ce, "R11 clock high during write stall", {bus_ce, bus_sclk}, 3);
      if (!wr_valid && wr_src_q.size() > 0) begin
        if (wr_wait >= wr_stall) begin
          wr_valid = 1;
          wr_data = wr_src_q[0];
        end else wr_wait++;
      end
      wr_hs = wr_valid && wr_ready;
    end
  end

  // ---------------- read byte monitor ----------------
  int rd_cnt;
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ready = 0; rd_cnt = 0;
    end else begin
      rd_cnt++;
      rd_ready = ((rd_cnt % rd_period) == 0);
      if (rd_valid && rd_ready) begin
        logic [7:0] e;
        chk(bus_sclk && bus_ce, "R6 clock and enable high between bytes", {bus_ce, bus_sclk}, 3);
        e = (rd_exp_q.size() > 0) ? rd_exp_q.pop_front() : 8'hxx;
        chk(rd_data === e, "R2 read byte", rd_data, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_txn(input logic [7:0] cmd, input int n, input int stall,
                         input int rdper, input bit poke);
    while (busy) @(negedge clk);
    cur_n = n; wr_stall = stall; rd_period = rdper;
    exp_bus_q.push_back(cmd);
    for (int k = 0; k < n; k++) begin
      if (cmd[0]) rd_exp_q.push_back(rsp(cmd, k));
      else begin
        exp_bus_q.push_back(wdat(cmd, k));
        wr_src_q.push_back(wdat(cmd, k));
      end
    end
    req_cmd = cmd; req_len = LW'(n); req_valid = 1;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    req_valid = 0;
    if (poke) begin
      req_cmd = 8'hFF; req_len = 4'd3; req_valid = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 refused while busy", req_ready, 0);
      end
      req_valid = 0;
    end
    while (busy) @(negedge clk);
    chk({bus_ce, bus_sclk, bus_dout, bus_doe} == 4'b0, "R7 idle lines",
        {bus_ce, bus_sclk, bus_dout, bus_doe}, 0);
    chk(exp_bus_q.size() == 0, "R8 all bus bytes seen", exp_bus_q.size(), 0);
    chk(rd_exp_q.size() == 0, "R8 all read bytes delivered", rd_exp_q.size(), 0);
    chk(wr_src_q.size() == 0, "R11 all write bytes taken", wr_src_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_cmd = 0; req_len = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({bus_ce, bus_sclk, bus_dout, bus_doe} == 4'b0, "R7 reset lines",
        {bus_ce, bus_sclk, bus_dout, bus_doe}, 0);
    chk(!busy && req_ready, "R10 reset idle", {busy, req_ready}, 1);
    chk(!rd_valid && !wr_ready, "R11 reset handshakes", {rd_valid, wr_ready}, 0);

    run_txn(8'h8E, 1, 0, 1, 0);   // single write, clock control register
    run_txn(8'h81, 1, 0, 1, 0);   // single read, seconds register
    run_txn(8'hBF, 7, 0, 5, 1);   // clock burst read, slow consumer, refusal probe
    run_txn(8'h8E, 1, 0, 1, 0);   // unprotect before burst write
    run_txn(8'hBE, 8, 80, 1, 0);  // clock burst write with stalls
    run_txn(8'hC1, 1, 0, 2, 0);   // RAM read (bit 6 set)
    run_txn(8'h90, 0, 0, 1, 0);   // command only
    run_txn(8'hFC, 3, 0, 1, 0);   // RAM burst-style write, no stall
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule